// File: doc/BRIEF.md
# Command Register Handoff with Write Lock

This block is the host-side register file for a card command engine that runs on its own clock. Software programs a command word, an argument, a block size, a byte count and a timeout over a simple register bus. When it writes the command register with bit 31 set, the block copies all five setup values into a holding register, raises its start flag, and sends a request toggle to the engine clock domain.

The engine domain detects the synchronized toggle and latches the held setup values into its own copy. It then presents them to the engine with a pending flag. When the engine accepts the command, an acknowledge toggle returns to the host domain and clears the start flag. Until that acknowledge arrives, the five setup registers are write-locked. A blocked write is dropped and flagged with a one-cycle pulse. A separate auxiliary register stays writable the whole time.

Reads are combinational from the address lines. Bit 31 of the command register reads back the live start flag, so software can poll it.

Top module: `cmd_reg_handoff`

## Requirements
- R1: After reset, the start flag is 0, every register reads 0, `illegal_write_o` is 0 and `eng_pending_o` is 0.
- R2: The word addresses are 0 command (bits 30:0 are fields, bit 31 is start), 1 argument, 2 block size (bits 15:0, upper bits read 0), 3 byte count, 4 timeout and 5 auxiliary. Addresses 6 and 7 read 0. When idle, a write updates the register and a read returns it.
- R3: Writing address 0 with bit 31 = 1 while idle sets the start flag, and address 0 then reads back with bit 31 = 1.
- R4: After a start, the engine side raises `eng_pending_o`. The `eng_*` field outputs then equal the command fields written with the start, together with the argument, block size, byte count and timeout values held at that moment.
- R5: While the start flag is set, writes to addresses 0 to 4 leave those registers unchanged. Each such write drives `illegal_write_o` high for exactly the one cycle after the write. Reads of these registers still return their current values.
- R6: While the start flag is set, the auxiliary register (address 5) accepts writes and does not raise `illegal_write_o`.
- R7: The start flag stays set until the engine accepts the command, and it clears within a few host cycles after the accept. An `eng_accept_i` pulse given while nothing is pending has no effect.
- R8: When idle, a write to address 0 with bit 31 = 0 updates the command fields and issues nothing to the engine.
- R9: `eng_pending_o` falls on the engine clock edge that samples `eng_accept_i` high while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Host domain reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| illegal_write_o | output | 1 | One-cycle pulse after a write blocked by the lock |
| eng_clk_i | input | 1 | Engine clock |
| eng_rst_ni | input | 1 | Engine domain reset, active low |
| eng_accept_i | input | 1 | Engine accepts the pending command |
| eng_pending_o | output | 1 | A command is waiting in the engine domain |
| eng_cmd_o | output | 31 | Command fields of the pending command |
| eng_arg_o | output | 32 | Argument of the pending command |
| eng_blksz_o | output | 16 | Block size of the pending command |
| eng_bytcnt_o | output | 32 | Byte count of the pending command |
| eng_tmout_o | output | 32 | Timeout of the pending command |

## Verification
Suppose the host-side lock or the start flag is wrong. The fault shows at once: the next locked write either changes a readback value or fails to pulse `illegal_write_o` on the following cycle. Suppose instead a toggle is lost or doubled in either synchronizer. Then `eng_pending_o` never rises within a handful of engine cycles, or the start bit never clears (or clears before any accept), and command-register polling shows this within a few host cycles. A snapshot captured at the wrong moment appears as a field mismatch on the `eng_*` outputs while pending is high.

// File: rtl/cmd_handoff_pkg.sv
package cmd_handoff_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CMD_W   = DATA_W - 1;
  localparam int unsigned BLK_W   = 16;
  localparam int unsigned START_B = DATA_W - 1;

  localparam logic [ADDR_W-1:0] A_CMD    = 3'd0;
  localparam logic [ADDR_W-1:0] A_ARG    = 3'd1;
  localparam logic [ADDR_W-1:0] A_BLKSZ  = 3'd2;
  localparam logic [ADDR_W-1:0] A_BYTCNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_TMOUT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_AUX    = 3'd5;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] arg;
    logic [BLK_W-1:0]  blksz;
    logic [DATA_W-1:0] bytcnt;
    logic [DATA_W-1:0] tmout;
  } setup_t;
endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tgl_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] ^ last_q;

  // one source toggle yields exactly one pulse
  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/cmd_host_regs.sv
module cmd_host_regs
  import cmd_handoff_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              illegal_write_o,
  input  logic              ack_pulse_i,
  output logic              req_tgl_o,
  output setup_t            snap_o
);
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] arg_q, bytcnt_q, tmout_q, aux_q;
  logic [BLK_W-1:0]  blksz_q;
  logic              start_q, req_tgl_q, illegal_q;
  setup_t            snap_q;

  logic wr, locked_addr, blocked, issue;

  assign wr          = req_i && we_i;
  assign locked_addr = (addr_i <= A_TMOUT);
  assign blocked     = wr && start_q && locked_addr;
  assign issue       = wr && !start_q && (addr_i == A_CMD) && wdata_i[START_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      arg_q     <= '0;
      blksz_q   <= '0;
      bytcnt_q  <= '0;
      tmout_q   <= '0;
      aux_q     <= '0;
      start_q   <= 1'b0;
      req_tgl_q <= 1'b0;
      illegal_q <= 1'b0;
      snap_q    <= '0;
    end else begin
      illegal_q <= blocked;
      if (ack_pulse_i) start_q <= 1'b0;
      if (wr && !blocked) begin
        unique case (addr_i)
          A_CMD:    cmd_q    <= wdata_i[CMD_W-1:0];
          A_ARG:    arg_q    <= wdata_i;
          A_BLKSZ:  blksz_q  <= wdata_i[BLK_W-1:0];
          A_BYTCNT: bytcnt_q <= wdata_i;
          A_TMOUT:  tmout_q  <= wdata_i;
          A_AUX:    aux_q    <= wdata_i;
          default: ;
        endcase
      end
      if (issue) begin
        start_q   <= 1'b1;
        req_tgl_q <= ~req_tgl_q;
        snap_q    <= '{cmd: wdata_i[CMD_W-1:0], arg: arg_q, blksz: blksz_q,
                       bytcnt: bytcnt_q, tmout: tmout_q};
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMD:    rdata_o = {start_q, cmd_q};
      A_ARG:    rdata_o = arg_q;
      A_BLKSZ:  rdata_o[BLK_W-1:0] = blksz_q;
      A_BYTCNT: rdata_o = bytcnt_q;
      A_TMOUT:  rdata_o = tmout_q;
      A_AUX:    rdata_o = aux_q;
      default:  rdata_o = '0;
    endcase
  end

  assign illegal_write_o = illegal_q;
  assign req_tgl_o       = req_tgl_q;
  assign snap_o          = snap_q;

  assert_locked_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> {cmd_q, arg_q, blksz_q, bytcnt_q, tmout_q} ==
                $past({cmd_q, arg_q, blksz_q, bytcnt_q, tmout_q}));
  assert_illegal_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_write_o |-> $past(req_i && we_i && start_q && (addr_i <= A_TMOUT)));
  assert_start_clear_on_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_q) |-> $past(ack_pulse_i));
  assert_snap_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && $past(start_q)) |-> $stable(snap_q));
endmodule

// File: rtl/cmd_eng_port.sv
module cmd_eng_port
  import cmd_handoff_pkg::*;
(
  input  logic   eng_clk_i,
  input  logic   eng_rst_ni,
  input  logic   req_pulse_i,
  input  setup_t snap_i,
  input  logic   accept_i,
  output logic   pending_o,
  output logic   ack_tgl_o,
  output setup_t setup_o
);
  logic   pending_q, ack_tgl_q;
  setup_t setup_q;

  always_ff @(posedge eng_clk_i or negedge eng_rst_ni) begin
    if (!eng_rst_ni) begin
      pending_q <= 1'b0;
      ack_tgl_q <= 1'b0;
      setup_q   <= '0;
    end else if (req_pulse_i) begin
      pending_q <= 1'b1;
      setup_q   <= snap_i;
    end else if (pending_q && accept_i) begin
      pending_q <= 1'b0;
      ack_tgl_q <= ~ack_tgl_q;
    end
  end

  assign pending_o = pending_q;
  assign ack_tgl_o = ack_tgl_q;
  assign setup_o   = setup_q;

  assert_accept_clears_R9: assert property (@(posedge eng_clk_i) disable iff (!eng_rst_ni)
    (pending_q && accept_i && !req_pulse_i) |=> !pending_q);
  assert_setup_stable_R4: assert property (@(posedge eng_clk_i) disable iff (!eng_rst_ni)
    (pending_q && !req_pulse_i) |=> $stable(setup_q));
  assert_idle_accept_R7: assert property (@(posedge eng_clk_i) disable iff (!eng_rst_ni)
    (!pending_q && !req_pulse_i) |=> $stable(ack_tgl_q));
endmodule

// File: rtl/cmd_reg_handoff.sv
module cmd_reg_handoff
  import cmd_handoff_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              illegal_write_o,
  input  logic              eng_clk_i,
  input  logic              eng_rst_ni,
  input  logic              eng_accept_i,
  output logic              eng_pending_o,
  output logic [CMD_W-1:0]  eng_cmd_o,
  output logic [DATA_W-1:0] eng_arg_o,
  output logic [BLK_W-1:0]  eng_blksz_o,
  output logic [DATA_W-1:0] eng_bytcnt_o,
  output logic [DATA_W-1:0] eng_tmout_o
);
  logic   req_tgl, ack_tgl, req_pulse, ack_pulse;
  setup_t snap, eng_setup;

  cmd_host_regs u_host (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .illegal_write_o,
    .ack_pulse_i(ack_pulse), .req_tgl_o(req_tgl), .snap_o(snap)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(eng_clk_i), .rst_ni(eng_rst_ni), .tgl_i(req_tgl), .pulse_o(req_pulse)
  );

  cmd_eng_port u_eng (
    .eng_clk_i, .eng_rst_ni, .req_pulse_i(req_pulse), .snap_i(snap),
    .accept_i(eng_accept_i), .pending_o(eng_pending_o), .ack_tgl_o(ack_tgl),
    .setup_o(eng_setup)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .tgl_i(ack_tgl), .pulse_o(ack_pulse)
  );

  assign eng_cmd_o    = eng_setup.cmd;
  assign eng_arg_o    = eng_setup.arg;
  assign eng_blksz_o  = eng_setup.blksz;
  assign eng_bytcnt_o = eng_setup.bytcnt;
  assign eng_tmout_o  = eng_setup.tmout;
endmodule

// File: tb/cmd_reg_handoff_tb.sv
module cmd_reg_handoff_tb_top;
  logic        clk = 0, eng_clk = 0, rst_n = 0, eng_rst_n = 0;
  logic        req = 0, we = 0, accept = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, arg, bytcnt, tmout;
  logic        illegal, pending;
  logic [30:0] cmd;
  logic [15:0] blksz;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;
  always #3.65 eng_clk = ~eng_clk;

  cmd_reg_handoff dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .illegal_write_o(illegal),
    .eng_clk_i(eng_clk), .eng_rst_ni(eng_rst_n), .eng_accept_i(accept),
    .eng_pending_o(pending), .eng_cmd_o(cmd), .eng_arg_o(arg),
    .eng_blksz_o(blksz), .eng_bytcnt_o(bytcnt), .eng_tmout_o(tmout)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output bit ill);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    ill = illegal;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #0.5 d = rdata;
  endtask

  task automatic wait_pending(output bit ok);
    ok = 0;
    for (int i = 0; i < 40 && !ok; i++) begin @(negedge eng_clk); ok = pending; end
  endtask

  task automatic do_accept;
    @(negedge eng_clk); accept = 1;
    @(negedge eng_clk); accept = 0;
  endtask

  task automatic wait_start_clear(output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int i = 0; i < 40 && !ok; i++) begin rd(3'd0, d); ok = !d[31]; end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d); check(d == 0, "R1 reg", d, 0);
    end
    check(!illegal, "R1 illegal", {31'b0, illegal}, 0);
    check(!pending, "R1 pending", {31'b0, pending}, 0);
  endtask

  task automatic t_readback;
    bit ill; logic [31:0] d;
    wr(3'd1, 32'hA5A5_0001, ill);
    wr(3'd2, 32'hABCD_1234, ill);
    wr(3'd3, 32'h0000_0200, ill);
    wr(3'd4, 32'h00FF_FFFF, ill);
    wr(3'd5, 32'h1357_9BDF, ill);
    rd(3'd1, d); check(d == 32'hA5A5_0001, "R2 arg", d, 32'hA5A5_0001);
    rd(3'd2, d); check(d == 32'h0000_1234, "R2 blksz", d, 32'h0000_1234);
    rd(3'd3, d); check(d == 32'h0000_0200, "R2 bytcnt", d, 32'h200);
    rd(3'd4, d); check(d == 32'h00FF_FFFF, "R2 tmout", d, 32'h00FF_FFFF);
    rd(3'd5, d); check(d == 32'h1357_9BDF, "R2 aux", d, 32'h1357_9BDF);
    rd(3'd6, d); check(d == 0, "R2 unmapped", d, 0);
    wr(3'd0, 32'h0000_00A5, ill);
    rd(3'd0, d); check(d == 32'h0000_00A5, "R8 cmd no start", d, 32'hA5);
    repeat (20) @(negedge eng_clk);
    check(!pending, "R8 no issue", {31'b0, pending}, 0);
  endtask

  task automatic t_issue(input logic [30:0] c, input logic [31:0] a);
    bit ill, ok; logic [31:0] d;
    wr(3'd1, a, ill);
    wr(3'd0, {1'b1, c}, ill);
    rd(3'd0, d); check(d == {1'b1, c}, "R3 start set", d, {1'b1, c});
    wait_pending(ok);
    check(ok, "R4 pending", {31'b0, pending}, 1);
    check(cmd == c, "R4 cmd", {1'b0, cmd}, {1'b0, c});
    check(arg == a, "R4 arg", arg, a);
    check(blksz == 16'h1234, "R4 blksz", {16'b0, blksz}, 32'h1234);
    check(bytcnt == 32'h200, "R4 bytcnt", bytcnt, 32'h200);
    check(tmout == 32'h00FF_FFFF, "R4 tmout", tmout, 32'h00FF_FFFF);
    wr(3'd1, 32'hDEAD_BEEF, ill);
    check(ill, "R5 illegal pulse", {31'b0, ill}, 1);
    @(negedge clk); check(!illegal, "R5 pulse width", {31'b0, illegal}, 0);
    rd(3'd1, d); check(d == a, "R5 arg locked", d, a);
    wr(3'd0, 32'h0000_0003, ill);
    check(ill, "R5 cmd illegal", {31'b0, ill}, 1);
    rd(3'd0, d); check(d == {1'b1, c}, "R5 cmd locked", d, {1'b1, c});
    wr(3'd5, a ^ 32'hFFFF_0000, ill);
    check(!ill, "R6 aux no illegal", {31'b0, ill}, 0);
    rd(3'd5, d); check(d == (a ^ 32'hFFFF_0000), "R6 aux written", d, a ^ 32'hFFFF_0000);
    repeat (30) @(negedge clk);
    rd(3'd0, d); check(d[31], "R7 start held", d, {1'b1, c});
    check(cmd == c && arg == a, "R4 engine hold", arg, a);
    do_accept;
    check(!pending, "R9 pending drop", {31'b0, pending}, 0);
    wait_start_clear(ok);
    check(ok, "R7 start cleared", {31'b0, !ok}, 0);
    wr(3'd1, a + 1, ill);
    rd(3'd1, d); check(d == a + 1 && !ill, "R5 unlocked", d, a + 1);
  endtask

  task automatic t_idle_accept;
    bit ill; logic [31:0] d;
    do_accept;
    repeat (10) @(negedge clk);
    rd(3'd0, d); check(!d[31], "R7 idle accept", d, 0);
    check(!pending, "R7 idle pending", {31'b0, pending}, 0);
    wr(3'd0, 32'h8000_0042, ill);
    rd(3'd0, d); check(d == 32'h8000_0042, "R7 still issues", d, 32'h8000_0042);
    repeat (30) @(negedge clk);
    rd(3'd0, d); check(d[31], "R7 no stray clear", d, 32'h8000_0042);
    do_accept;
    begin bit ok; wait_start_clear(ok); check(ok, "R7 clear after accept", 0, 0); end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge eng_clk); eng_rst_n = 1;
    t_reset;
    t_readback;
    t_issue(31'h0000_0011, 32'hCAFE_0001);
    t_issue(31'h4000_0F0F, 32'h0102_0304);
    t_idle_accept;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule